// File: doc/BRIEF.md
# Asynchronous DRAM Host Controller

This block sits between a simple host port and a multiplexed-address asynchronous DRAM. The host raises a request carrying a 21-bit byte address, a direction bit and write data, and holds it until the controller answers with a one-cycle completion pulse. For a read, the captured byte is presented in that same cycle. The controller turns each request into row strobe, column strobe, write-enable and output-enable sequences. The upper address bits go out as the row and the lower bits as the column, both on one shared 11-bit pin bus.

Out of reset the controller first waits through a long power-up pause. It then runs a fixed number of dummy row-strobe cycles before it accepts any host access. After that, an interval timer requests a refresh of the CAS-before-RAS kind at a fixed period. A pending refresh wins over a waiting host request at the next idle point, and the held request is served right after. Every strobe active and precharge time is a parameter counted in clock cycles. Writes always use early-write ordering.

Top module: `dram_host_ctrl`

## Requirements
- R1: While reset is asserted, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_oe` and `host_done` are 0.
- R2: After reset release, `dram_ras_n` stays high for at least `PWRUP_CYC` clock cycles. Then at least `INIT_CYC` row-strobe pulses with `dram_cas_n` high are issued before the first `host_done` pulse.
- R3: Every low period of `dram_ras_n` lasts at least `T_RAS` cycles.
- R4: Every high period of `dram_ras_n` between two low periods lasts at least max(`T_RP`, `T_CP`) cycles. Every high period of `dram_cas_n` between two low periods lasts at least `T_CP` cycles.
- R5: For an access, `dram_a` carries `host_addr[20:10]` when `dram_ras_n` falls. It carries `{1'b0, host_addr[9:0]}` when `dram_cas_n` falls.
- R6: For a write (`host_we`=1), `dram_we_n` is already low in the cycle before `dram_cas_n` falls. At the CAS fall, `dram_dq_oe` is 1 and `dram_dq_out` equals the write byte.
- R7: For a read (`host_we`=0), `dram_we_n` stays high and `dram_oe_n` goes low together with the CAS fall. `dram_dq_in` is captured after `dram_cas_n` has been low for at least `T_RD` cycles, and the byte appears on `host_rdata` in the `host_done` cycle.
- R8: Once initialization ends, a refresh is issued once every `REF_INT` cycles, give or take one access length. In a refresh, `dram_cas_n` falls at least one cycle before `dram_ras_n`, `dram_we_n` and `dram_oe_n` stay high and `dram_dq_oe` stays 0.
- R9: When a refresh is due while a host request waits, the refresh runs first. The request is then completed with correct data.
- R10: `host_done` is a single-cycle pulse, and there is exactly one pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Byte address (row in the upper bits) |
| host_wdata | input | 8 | Write byte |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid with `host_done` |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | 1 while the controller drives the data bus |
| dram_dq_in | input | 8 | Data returned by the DRAM |

## Verification
The bench builds the controller with a 50-cycle power-up pause, eight init pulses and a 120-cycle refresh interval. This lets initialization finish quickly and lets many refreshes land in the middle of back-to-back host traffic, which is where the refresh-priority case arises. Timing is set to T_RAS=5, T_RP=3, T_CP=2, T_RCD=2 and T_RD=4. With these values the column phase is stretched by the read delay and not by tRAS. Row and column precharge also differ, so a mix-up between them shows at the pins.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_INIT_RAS,
    ST_INIT_PRE,
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_PRE,
    ST_REF_CAS,
    ST_REF_RAS
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                      oe_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned REF_INT = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int unsigned TW = $clog2(REF_INT + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;
  logic          tick;

  always_comb begin
    tick   = 1'b0;
    tmr_d  = tmr_q;
    pend_d = pend_q;
    if (!run_en) begin
      tmr_d  = TW'(REF_INT - 1);
      pend_d = 1'b0;
    end else begin
      if (tmr_q == '0) begin
        tick  = 1'b1;
        tmr_d = TW'(REF_INT - 1);
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
      if (tick)         pend_d = 1'b1;
      else if (ref_ack) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= TW'(REF_INT - 1);
      pend_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
    end
  end

  assign ref_pend = pend_q;

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PIN_AW = 11,
  parameter int unsigned ROW_W  = 11
) (
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [PIN_AW-1:0] row_pins,
  output logic [PIN_AW-1:0] col_pins
);
  localparam int unsigned COL_W = ADDR_W - ROW_W;

  generate
    if (ROW_W < PIN_AW) begin : g_row_pad
      assign row_pins = {{(PIN_AW-ROW_W){1'b0}}, acc_addr[ADDR_W-1:COL_W]};
    end else begin : g_row_full
      assign row_pins = acc_addr[ADDR_W-1:COL_W];
    end
    if (COL_W < PIN_AW) begin : g_col_pad
      assign col_pins = {{(PIN_AW-COL_W){1'b0}}, acc_addr[COL_W-1:0]};
    end else begin : g_col_full
      assign col_pins = acc_addr[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PIN_AW    = 11,
  parameter int unsigned PWRUP_CYC = 20000,
  parameter int unsigned INIT_CYC  = 8,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_CP      = 1,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_RD      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic              init_done,
  output logic [ADDR_W-1:0] acc_addr,
  input  logic [PIN_AW-1:0] row_pins,
  input  logic [PIN_AW-1:0] col_pins,
  output pin_ctl_t          pins,
  output logic [PIN_AW-1:0] dram_a,
  output logic [DATA_W-1:0] dq_out,
  input  logic [DATA_W-1:0] dq_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PRE_CYC = max2(T_RP, T_CP);
  localparam int unsigned COL_CYC = max2(T_RD, (T_RAS > T_RCD) ? (T_RAS - T_RCD) : 1);
  localparam int unsigned MAXD    = max2(max2(PWRUP_CYC, T_RAS), max2(max2(PRE_CYC, T_RCD), COL_CYC));
  localparam int unsigned CNT_W   = $clog2(MAXD + 1);
  localparam int unsigned INIT_W  = $clog2(INIT_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [INIT_W-1:0] init_q, init_d;
  logic              cnt0, accept, cap;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, sel_we;
  logic [DATA_W-1:0] wd_q;
  pin_ctl_t          pins_q, pins_d;
  logic [PIN_AW-1:0] a_q, a_d;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              init_done_q;

  function automatic logic [CNT_W-1:0] dur_m1(input seq_state_e s);
    case (s)
      ST_PWRUP:    return CNT_W'(PWRUP_CYC - 1);
      ST_INIT_RAS: return CNT_W'(T_RAS - 1);
      ST_INIT_PRE: return CNT_W'(PRE_CYC - 1);
      ST_ACT:      return CNT_W'(T_RCD - 1);
      ST_COL:      return CNT_W'(COL_CYC - 1);
      ST_PRE:      return CNT_W'(PRE_CYC - 1);
      ST_REF_RAS:  return CNT_W'(T_RAS - 1);
      default:     return '0;
    endcase
  endfunction

  // next-state and dwell counter
  always_comb begin
    state_d = state_q;
    init_d  = init_q;
    cnt0    = (cnt_q == '0);
    cnt_d   = cnt0 ? cnt_q : cnt_q - 1'b1;
    case (state_q)
      ST_PWRUP:    if (cnt0) state_d = ST_INIT_RAS;
      ST_INIT_RAS: if (cnt0) state_d = ST_INIT_PRE;
      ST_INIT_PRE: if (cnt0) begin
        if (init_q == INIT_W'(INIT_CYC - 1)) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_INIT_RAS;
          init_d  = init_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (ref_pend) state_d = ST_REF_CAS;
        else if (req) state_d = ST_ACT;
      end
      ST_ACT:      if (cnt0) state_d = ST_COL;
      ST_COL:      if (cnt0) state_d = ST_PRE;
      ST_PRE:      if (cnt0) state_d = ST_IDLE;
      ST_REF_CAS:  if (cnt0) state_d = ST_REF_RAS;
      ST_REF_RAS:  if (cnt0) state_d = ST_PRE;
      default:     state_d = ST_IDLE;
    endcase
    if (state_d != state_q) cnt_d = dur_m1(state_d);
  end

  assign accept   = (state_q == ST_IDLE) && (state_d == ST_ACT);
  assign ref_ack  = (state_q == ST_IDLE) && (state_d == ST_REF_CAS);
  assign cap      = (state_q == ST_COL) && cnt0;
  assign acc_addr = accept ? req_addr : addr_q;
  assign sel_we   = accept ? req_we : wr_q;

  // pin decode of the state being entered
  always_comb begin
    pins_d       = PINS_QUIET;
    pins_d.ras_n = !(state_d inside {ST_INIT_RAS, ST_ACT, ST_COL, ST_REF_RAS});
    pins_d.cas_n = !(state_d inside {ST_COL, ST_REF_CAS, ST_REF_RAS});
    pins_d.we_n  = !(sel_we && (state_d inside {ST_ACT, ST_COL}));
    pins_d.dq_oe =   sel_we && (state_d inside {ST_ACT, ST_COL});
    pins_d.oe_n  = !(!sel_we && (state_d == ST_COL));
    case (state_d)
      ST_ACT:      a_d = row_pins;
      ST_COL:      a_d = col_pins;
      ST_INIT_RAS: a_d = PIN_AW'(init_d);
      default:     a_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PWRUP;
      cnt_q       <= CNT_W'(PWRUP_CYC - 1);
      init_q      <= '0;
      pins_q      <= PINS_QUIET;
      a_q         <= '0;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      wd_q        <= '0;
      done_q      <= 1'b0;
      rdata_q     <= '0;
      init_done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      pins_q  <= pins_d;
      a_q     <= a_d;
      done_q  <= cap;
      if (accept) begin
        addr_q <= req_addr;
        wr_q   <= req_we;
        wd_q   <= req_wdata;
      end
      if (cap && !wr_q) rdata_q <= dq_in;
      if ((state_q == ST_INIT_PRE) && (state_d == ST_IDLE)) init_done_q <= 1'b1;
    end
  end

  assign pins      = pins_q;
  assign dram_a    = a_q;
  assign dq_out    = wd_q;
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign init_done = init_done_q;

endmodule

// File: rtl/dram_host_ctrl.sv
module dram_host_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PIN_AW    = 11,
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned PWRUP_CYC = 20000,
  parameter int unsigned INIT_CYC  = 8,
  parameter int unsigned REF_INT   = 1560,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_CP      = 1,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_RD      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [PIN_AW-1:0] dram_a,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              ref_pend, ref_ack, init_done;
  logic [ADDR_W-1:0] acc_addr;
  logic [PIN_AW-1:0] row_pins, col_pins;
  pin_ctl_t          pins;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dram_refresh_timer #(.REF_INT(REF_INT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_en   (init_done),
    .ref_ack  (ref_ack),
    .ref_pend (ref_pend)
  );

  dram_addr_split #(.ADDR_W(ADDR_W), .PIN_AW(PIN_AW), .ROW_W(ROW_W)) u_split (
    .acc_addr (acc_addr),
    .row_pins (row_pins),
    .col_pins (col_pins)
  );

  dram_strobe_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_AW(PIN_AW), .PWRUP_CYC(PWRUP_CYC),
    .INIT_CYC(INIT_CYC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP),
    .T_RCD(T_RCD), .T_RD(T_RD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req       (host_req),
    .req_we    (host_we),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .init_done (init_done),
    .acc_addr  (acc_addr),
    .row_pins  (row_pins),
    .col_pins  (col_pins),
    .pins      (pins),
    .dram_a    (dram_a),
    .dq_out    (dram_dq_out),
    .dq_in     (dram_dq_in),
    .done      (host_done),
    .rdata     (host_rdata)
  );

  assign dram_ras_n = pins.ras_n;
  assign dram_cas_n = pins.cas_n;
  assign dram_we_n  = pins.we_n;
  assign dram_oe_n  = pins.oe_n;
  assign dram_dq_oe = pins.dq_oe;

endmodule

// File: rtl/dram_host_ctrl_chk.sv
module dram_host_ctrl_chk #(
  parameter int unsigned T_RAS    = 6,
  parameter int unsigned T_RP     = 4,
  parameter int unsigned T_CP     = 1,
  parameter int unsigned INIT_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);
  localparam int unsigned PRE_CYC = (T_RP > T_CP) ? T_RP : T_CP;

  logic [7:0] ras_lo_cnt, ras_hi_cnt, cas_hi_cnt, pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= '0;
      cas_hi_cnt <= '0;
      pulse_cnt  <= '0;
    end else begin
      ras_lo_cnt <= ras_n ? 8'd0 : ((ras_lo_cnt == 8'hFF) ? ras_lo_cnt : ras_lo_cnt + 8'd1);
      ras_hi_cnt <= !ras_n ? 8'd0 : ((ras_hi_cnt == 8'hFF) ? ras_hi_cnt : ras_hi_cnt + 8'd1);
      cas_hi_cnt <= !cas_n ? 8'd0 : ((cas_hi_cnt == 8'hFF) ? cas_hi_cnt : cas_hi_cnt + 8'd1);
      if ($fell(ras_n) && (pulse_cnt != 8'hFF)) pulse_cnt <= pulse_cnt + 8'd1;
    end
  end

  // R3
  ras_active_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_cnt >= 8'(T_RAS)));

  // R4
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_cnt >= 8'(PRE_CYC)));

  // R4
  cas_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (cas_hi_cnt >= 8'(T_CP)));

  // R8
  refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (we_n && oe_n && !dq_oe));

  // R6
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |-> ($past(!we_n) && dq_oe));

  // R7
  read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && we_n) |-> (!oe_n && !dq_oe));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  init_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pulse_cnt >= 8'(INIT_CYC)));

endmodule

bind dram_host_ctrl dram_host_ctrl_chk #(
  .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .INIT_CYC(INIT_CYC)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .done  (host_done),
  .ras_n (dram_ras_n),
  .cas_n (dram_cas_n),
  .we_n  (dram_we_n),
  .oe_n  (dram_oe_n),
  .dq_oe (dram_dq_oe)
);

// File: tb/dram_host_ctrl_tb_top.sv
module dram_host_ctrl_tb_top;
  localparam int unsigned PWRUP_CYC = 50;
  localparam int unsigned INIT_CYC  = 8;
  localparam int unsigned REF_INT   = 120;
  localparam int unsigned T_RAS     = 5;
  localparam int unsigned T_RP      = 3;
  localparam int unsigned T_CP      = 2;
  localparam int unsigned T_RCD     = 2;
  localparam int unsigned T_RD      = 4;
  localparam int unsigned PRE_CYC   = (T_RP > T_CP) ? T_RP : T_CP;

  logic        clk, rst_n;
  logic        host_req, host_we;
  logic [20:0] host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        host_done;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [10:0] dram_a;
  logic [7:0]  dq_out, dq_in;

  dram_host_ctrl #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_CYC(INIT_CYC), .REF_INT(REF_INT),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_RD(T_RD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_done(host_done),
    .host_rdata(host_rdata), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_a(dram_a), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard items
  typedef struct {
    bit         wr;
    logic [20:0] a;
    logic [7:0]  d;
  } exp_t;
  exp_t exp_q[$];
  logic [7:0] shadow [logic [20:0]];

  logic [20:0] cur_addr;
  logic [7:0]  cur_wd;
  int issued = 0;
  int dones  = 0;

  // DRAM pin model and pin-level timing checks
  logic [7:0]  mem [logic [20:0]];
  logic        prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [10:0] row_l;
  int lo_run = 0, hi_run = 0, cas_hi_run = 0;
  int pw_cnt = 0;
  bit seen_fall = 0, seen_cas_fall = 0, first_done = 0;
  int init_pulses = 0;
  int refreshes = 0, collisions = 0;
  int cyc = 0, last_ref = -1;
  logic [7:0] rd_byte = 8'h00;
  assign dq_in = rd_byte;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !host_done, "R1 reset pins",
          {27'd0, ras_n, cas_n, we_n, oe_n, dq_oe}, 32'h1E);
    end else begin
      cyc++;
      if (prev_ras && !ras_n) begin
        if (!seen_fall) chk(pw_cnt >= int'(PWRUP_CYC), "R2 power-up pause", pw_cnt, PWRUP_CYC);
        else            chk(hi_run >= int'(PRE_CYC), "R4 RAS precharge", hi_run, PRE_CYC);
        seen_fall = 1;
        if (!cas_n) begin
          refreshes++;
          chk(we_n && oe_n && !dq_oe && !prev_cas, "R8 refresh strobes",
              {28'd0, we_n, oe_n, dq_oe, prev_cas}, 32'hC);
          if (last_ref >= 0)
            chk((cyc - last_ref <= int'(REF_INT) + 12) && (cyc - last_ref >= int'(REF_INT) - 12),
                "R8 refresh interval", cyc - last_ref, REF_INT);
          last_ref = cyc;
          if (host_req) collisions++;
        end else begin
          row_l = dram_a;
          if (!first_done) init_pulses++;
        end
      end
      if (!prev_ras && ras_n) chk(lo_run >= int'(T_RAS), "R3 RAS active time", lo_run, T_RAS);
      if (prev_cas && !cas_n) begin
        if (seen_cas_fall) chk(cas_hi_run >= int'(T_CP), "R4 CAS precharge", cas_hi_run, T_CP);
        seen_cas_fall = 1;
      end
      if (prev_cas && !cas_n && !ras_n && !prev_ras) begin
        chk(row_l == cur_addr[20:10], "R5 row bits", row_l, cur_addr[20:10]);
        chk(dram_a == {1'b0, cur_addr[9:0]}, "R5 column bits", dram_a, {1'b0, cur_addr[9:0]});
        if (!we_n) begin
          chk(!prev_we && dq_oe && dq_out == cur_wd, "R6 early write",
              {prev_we, dq_oe, dq_out}, {2'b01, cur_wd});
          mem[{row_l, dram_a[9:0]}] = dq_out;
        end else begin
          chk(!oe_n && !dq_oe, "R7 read strobes", {oe_n, dq_oe}, 0);
          rd_byte = mem.exists({row_l, dram_a[9:0]}) ? mem[{row_l, dram_a[9:0]}] : 8'h00;
        end
      end
      if (!seen_fall && ras_n) pw_cnt++;
      lo_run     = ras_n ? 0 : lo_run + 1;
      hi_run     = ras_n ? hi_run + 1 : 0;
      cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
    prev_we  = we_n;
  end

  // monitor: pops the scoreboard on each completion
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_done) chk(!prev_done, "R10 done width", 2, 1);
      if (host_done && !prev_done) begin
        dones++;
        if (!first_done) begin
          chk(init_pulses >= int'(INIT_CYC), "R2 init pulses before first access", init_pulses, INIT_CYC);
          first_done = 1;
        end
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (!e.wr) chk(host_rdata == e.d, "R7 read data", host_rdata, e.d);
        end
      end
      prev_done = host_done;
    end
  end

  // driver
  task automatic access(input bit wr, input logic [20:0] a, input logic [7:0] d);
    exp_t e;
    e.wr = wr;
    e.a  = a;
    e.d  = wr ? d : (shadow.exists(a) ? shadow[a] : 8'h00);
    if (wr) shadow[a] = d;
    exp_q.push_back(e);
    @(negedge clk);
    cur_addr   = a;
    cur_wd     = d;
    host_req   = 1'b1;
    host_we    = wr;
    host_addr  = a;
    host_wdata = d;
    issued++;
    do @(negedge clk); while (!host_done);
    host_req = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // request raised at once: must wait for init (R2)
    access(1'b1, 21'h000000, 8'hA5);
    access(1'b1, 21'h1FFFFF, 8'h3C);
    access(1'b1, 21'h155555, 8'h96);
    access(1'b1, 21'h0AAAAA, 8'h69);
    access(1'b1, {11'h005, 10'h3FF}, 8'h11);
    access(1'b1, {11'h7FF, 10'h000}, 8'hEE);
    access(1'b0, 21'h0AAAAA, 8'h00);
    access(1'b0, 21'h000000, 8'h00);
    access(1'b0, {11'h7FF, 10'h000}, 8'h00);
    access(1'b0, 21'h1FFFFF, 8'h00);
    access(1'b0, {11'h005, 10'h3FF}, 8'h00);
    access(1'b0, 21'h155555, 8'h00);
    access(1'b1, 21'h155555, 8'h42);
    access(1'b0, 21'h155555, 8'h00);
    // back-to-back traffic across several refresh intervals (R9)
    for (int i = 0; i < 60; i++) begin
      logic [20:0] a;
      a = 21'(i * 33331 + 7);
      access(1'b1, a, 8'(i ^ 8'h5A));
      access(1'b0, a, 8'h00);
    end
    // idle: refreshes continue alone (R8)
    repeat (600) @(negedge clk);
    chk(dones == issued && exp_q.size() == 0, "R10 one done per request", dones, issued);
    chk(refreshes >= 8, "R8 refresh count", refreshes, 8);
    chk(collisions > 0, "R9 refresh ahead of waiting request", collisions, 1);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

endmodule